// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial memory. A fast system clock oversamples the bus clock and data lines and passes each through its own synchronizer. The block finds start and stop conditions and shifts in a device select byte. It acknowledges that byte when the byte names this device. It then takes a memory address and either stores incoming data bytes or returns stored bytes. The storage is an internal 512-byte array. The block drives the data line only by pulling it low, so the enclosing chip provides an open-drain pad and a pull-up.

An internal pointer keeps the location just past the last byte accessed. A read with no preceding address therefore continues from where the previous transfer stopped. A random read is a write transfer that carries only the address, followed by a repeated start in the read direction. A write-protect input blocks every store to the array. The bytes are still acknowledged. A parameter picks one of two modes. In the large-array mode, one select bit carries the ninth memory address bit. In the small-array mode, that select bit must match a third strap pin. Non-volatile programming time is handled by a separate block and is not modelled here.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A start is the synchronized data line falling while the clock is high, and a stop is it rising while the clock is high. Either one in the middle of a byte abandons that byte with no store, and a start restarts device selection.
- R2: The select byte is sent most significant bit first as 1010, then a bit compared with strap_i[2], then a bit compared with strap_i[1], then the a8/strap bit, then the direction bit (1 = read, 0 = write). On a mismatch the block does not acknowledge and ignores the bus until the next start.
- R3: After each received byte that is accepted (select, address, data), the block pulls the data line low for the whole ninth clock period.
- R4: Each data byte in a write is stored at the pointer. The pointer then advances with its three low bits wrapping inside the 8-byte page, so a write longer than 8 bytes overwrites the earliest bytes of that page.
- R5: While wp_i is high, no byte is stored. Data bytes are still acknowledged, and the pointer still advances as in R4.
- R6: A write transfer holding only an address, then a repeated start with the direction bit 1, returns the byte at that address.
- R7: Read data leaves most significant bit first and changes only after a clock falling edge. An acknowledge of 0 from the master moves to the next address, and address 511 is followed by address 0.
- R8: After a read byte the master may answer with a 1 (no acknowledge). The block then releases the line and drives nothing until the next start, whether or not a stop follows.
- R9: Reset sets the pointer to 0. A read with no address phase starts at the pointer, which holds the last accessed address plus one: page-wrapped after writes, full-array-wrapped after reads.
- R10: In large-array mode (default), select bit 1 becomes memory address bit a8 on writes and strap_i[0] is ignored. In small-array mode, all three strap bits must match.
- R11: The pull-down output changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (wired-AND level) |
| strap_i | input | 3 | Hard-wired device select straps |
| wp_i | input | 1 | Write protect, high blocks all stores |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
A wrong bit counter or state would show at the ports within one byte. The acknowledge pulse would land on the wrong clock, or the master would see a missing acknowledge at the ninth clock. A corrupted pointer cannot be seen until the next read: a current-address read or the next byte of a sequential read returns data from the wrong location. The bench therefore follows every write style with a read that does not reload the address. A lost write-protect gate shows only when a protected location is read back. A release that comes too late after a stop or a non-acknowledge shows as the line held low while the master is idle.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int          ADDR_W   = 9;
    localparam int          PAGE_W   = 3;
    localparam int          MEM_SIZE = 1 << ADDR_W;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef logic [ADDR_W-1:0] mem_addr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_MADR,
        ST_WDAT,
        ST_ACKPEND,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_RNEXT
    } tgt_state_t;

    typedef struct packed {
        logic       we;
        mem_addr_t  addr;
        logic [7:0] data;
    } wr_req_t;

    // Select byte match: code, two straps always, third only in small mode
    function automatic logic dev_match(input logic [7:0] w,
                                       input logic [2:0] strap,
                                       input logic       wide);
        return (w[7:4] == DEV_CODE) && (w[3] == strap[2]) &&
               (w[2] == strap[1]) && (wide || (w[1] == strap[0]));
    endfunction

    // Pointer step after a read: whole array wraps
    function automatic mem_addr_t seq_next(input mem_addr_t a, input logic wide);
        mem_addr_t n;
        n = a + mem_addr_t'(1);
        if (!wide) n[ADDR_W-1] = 1'b0;
        return n;
    endfunction

    // Pointer step after a write: stays inside the page
    function automatic mem_addr_t page_next(input mem_addr_t a);
        logic [PAGE_W-1:0] lo;
        lo = a[PAGE_W-1:0] + PAGE_W'(1);
        return {a[ADDR_W-1:PAGE_W], lo};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[g]),
            .q   (synced[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_rise  = synced[1] & ~prev[1];
    assign scl_fall  = ~synced[1] & prev[1];
    assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
    assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array
    import eeprom_pkg::*;
(
    input  logic       clk,
    input  wr_req_t    wr,
    input  mem_addr_t  rd_addr,
    output logic [7:0] rd_data
);
    logic [7:0] cells [MEM_SIZE];

    always_ff @(posedge clk) begin
        if (wr.we) cells[wr.addr] <= wr.data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
    import eeprom_pkg::*;
#(
    parameter logic WIDE_MODE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    input  logic [7:0] rd_data,
    output mem_addr_t  rd_addr,
    output wr_req_t    wr,
    output logic       pull,
    output tgt_state_t st
);
    tgt_state_t st_q, ack_next;
    logic [2:0] cnt;
    logic [7:0] rx_sr, tx_sr;
    mem_addr_t  ptr;
    logic [7:0] byte_in;
    logic       last_bit;

    assign byte_in  = {rx_sr[6:0], sda_s};
    assign last_bit = scl_rise && (cnt == 3'd7);
    assign rd_addr  = ptr;
    assign st       = st_q;

    always_comb begin
        wr.we   = (st_q == ST_WDAT) && last_bit && !wp_i && !start_det && !stop_det;
        wr.addr = ptr;
        wr.data = byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ack_next <= ST_IDLE;
            cnt      <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            pull     <= 1'b0;
            ptr      <= '0;
        end else if (start_det) begin
            st_q <= ST_DEV;
            cnt  <= '0;
            pull <= 1'b0;
        end else if (stop_det) begin
            st_q <= ST_IDLE;
            cnt  <= '0;
            pull <= 1'b0;
        end else begin
            unique case (st_q)
                ST_DEV, ST_MADR, ST_WDAT: begin
                    if (scl_rise) begin
                        rx_sr <= byte_in;
                        cnt   <= cnt + 3'd1;
                    end
                    if (last_bit) begin
                        st_q <= ST_ACKPEND;
                        if (st_q == ST_DEV) begin
                            if (!dev_match(byte_in, strap_i, WIDE_MODE)) begin
                                st_q <= ST_IDLE;
                            end else if (byte_in[0]) begin
                                ack_next <= ST_TX;
                            end else begin
                                ack_next <= ST_MADR;
                                if (WIDE_MODE) ptr[ADDR_W-1] <= byte_in[1];
                            end
                        end else if (st_q == ST_MADR) begin
                            ptr[7:0] <= byte_in;
                            ack_next <= ST_WDAT;
                        end else begin
                            ptr      <= page_next(ptr);
                            ack_next <= ST_WDAT;
                        end
                    end
                end
                ST_ACKPEND: begin
                    if (scl_fall) begin
                        pull <= 1'b1;
                        st_q <= ST_ACK;
                    end
                end
                ST_ACK, ST_RNEXT: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (st_q == ST_RNEXT || ack_next == ST_TX) begin
                            tx_sr <= rd_data;
                            pull  <= ~rd_data[7];
                            st_q  <= ST_TX;
                        end else begin
                            pull <= 1'b0;
                            st_q <= ack_next;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == 3'd7) begin
                            pull <= 1'b0;
                            cnt  <= '0;
                            st_q <= ST_RACK;
                        end else begin
                            tx_sr <= {tx_sr[6:0], 1'b0};
                            pull  <= ~tx_sr[6];
                            cnt   <= cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ptr  <= seq_next(ptr, WIDE_MODE);
                        st_q <= sda_s ? ST_IDLE : ST_RNEXT;
                    end
                end
                default: begin
                    pull <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eeprom_pkg::*;
#(
    parameter logic WIDE_MODE   = 1'b1,
    parameter int   SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_data;
    mem_addr_t  rd_addr;
    wr_req_t    wr;
    tgt_state_t st;

    i2c_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeprom_ctrl #(.WIDE_MODE(WIDE_MODE)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (strap_i),
        .wp_i      (wp_i),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr        (wr),
        .pull      (sda_pull_o),
        .st        (st)
    );

    eeprom_array u_array (
        .clk     (clk),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker
    import eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       stop_det,
    input logic       wp_i,
    input logic       mem_we,
    input logic       sda_pull_o,
    input tgt_state_t st
);
    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_pull_o);

    // R11
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_s);

    // R5
    wp_block_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !wp_i);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_pull_o);

    // R3
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK && scl_s) |-> sda_pull_o);
endmodule

bind eeprom_i2c_target eeprom_i2c_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .wp_i       (wp_i),
    .mem_we     (wr.we),
    .sda_pull_o (sda_pull_o),
    .st         (st)
);

// File: tb/eeprom_i2c_target_test.sv
module eeprom_i2c_target_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic wp = 1'b0;
    wire  sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    eeprom_i2c_target uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .wp_i       (wp),
        .sda_pull_o (sda_pull)
    );

    int total = 0;
    int bad = 0;
    int viol = 0;
    bit done = 1'b0;
    logic [7:0] ref_mem [512];
    bit         known [512];
    logic [8:0] ref_addr = '0;
    logic       prev_pull = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic rw, input logic a8);
        return {4'b1010, strap[2], strap[1], a8, rw};
    endfunction

    function automatic logic [8:0] page_step(input logic [8:0] a);
        return {a[8:3], 3'(a[2:0] + 3'd1)};
    endfunction

    // R11 monitor: pull must not change while the bus clock is high
    always @(posedge clk) begin
        #2;
        if (!rst && (sda_pull !== prev_pull) && scl_m) viol++;
        prev_pull = sda_pull;
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(HALF);
        if (!scl_m) begin scl_m = 1'b1; tick(HALF); end
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF/2);
        b = sda_line; tick(HALF/2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
        put_bit(!mack);
    endtask

    task automatic write_txn(input logic [8:0] a, input int n);
        logic ack;
        logic [7:0] d;
        string tag;
        tag = wp ? "R5" : "R4";
        bus_start();
        send_byte(dev(1'b0, a[8]), ack); chk("R2", ack, 1);
        send_byte(a[7:0], ack);          chk("R3", ack, 1);
        ref_addr = a;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack); chk(tag, ack, 1);
            if (!wp) begin ref_mem[ref_addr] = d; known[ref_addr] = 1'b1; end
            ref_addr = page_step(ref_addr);
        end
        bus_stop();
    endtask

    task automatic read_bytes(input int n, input string req, input bit stop_after);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            if (known[ref_addr]) chk(req, d, ref_mem[ref_addr]);
            ref_addr = ref_addr + 9'd1;
        end
        if (stop_after) bus_stop();
    endtask

    task automatic read_random(input logic [8:0] a, input int n, input string req, input bit stop_after);
        logic ack;
        bus_start();
        send_byte(dev(1'b0, a[8]), ack); chk("R6", ack, 1);
        send_byte(a[7:0], ack);          chk("R6", ack, 1);
        ref_addr = a;
        bus_start();
        send_byte(dev(1'b1, 1'($urandom)), ack); chk("R6", ack, 1);
        read_bytes(n, req, stop_after);
    endtask

    task automatic read_current(input int n, input string req);
        logic ack;
        bus_start();
        send_byte(dev(1'b1, 1'b0), ack); chk("R9", ack, 1);
        read_bytes(n, req, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack, b;
        logic [7:0] d;
        logic [8:0] a;
        int kind, n;
        void'($urandom(32'd2024));
        tick(5); rst = 1'b0; tick(5);
        chk("R8 reset release", sda_pull, 0);

        // R9: pointer returns to zero on reset
        write_txn(9'h000, 1);
        rst = 1'b1; tick(3); rst = 1'b0; tick(3);
        ref_addr = 9'h000;
        read_current(1, "R9");

        // R2: wrong code and wrong strap are ignored
        bus_start();
        send_byte({4'b1110, strap[2], strap[1], 2'b00}, ack); chk("R2 code", ack, 0);
        send_byte(8'h00, ack); chk("R2 standby", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1010, ~strap[2], strap[1], 2'b00}, ack); chk("R2 strap", ack, 0);
        bus_stop();

        // R10: a8 in select byte, strap_i[0] ignored
        strap = 3'b100;
        write_txn(9'h0FF, 1);
        write_txn(9'h1FF, 1);
        strap = 3'b101;
        read_random(9'h0FF, 1, "R10", 1'b1);
        read_random(9'h1FF, 1, "R10", 1'b1);

        // R4: page wrap on long write, then R9 page-wrapped pointer
        write_txn(9'h013, 10);
        read_current(1, "R9");
        read_random(9'h010, 8, "R4", 1'b1);

        // R5: write protect
        wp = 1'b1;
        write_txn(9'h013, 4);
        wp = 1'b0;
        read_random(9'h010, 8, "R5", 1'b1);

        // R7: sequential read across the array end
        write_txn(9'h1FE, 2);
        write_txn(9'h000, 4);
        read_random(9'h1FE, 5, "R7", 1'b1);
        read_current(1, "R9");

        // R8: no acknowledge and no stop, line stays released
        read_random(9'h011, 1, "R6", 1'b0);
        for (int i = 0; i < 9; i++) begin
            get_bit(b); chk("R8", b, 1);
        end
        bus_stop();
        read_current(1, "R9");

        // R1: stop inside a data byte abandons it
        write_txn(9'h040, 1);
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack); chk("R1", ack, 1);
        send_byte(8'h40, ack);           chk("R1", ack, 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        read_random(9'h040, 1, "R1", 1'b1);

        // R1: start inside a byte restarts selection
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack); chk("R1", ack, 1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack); chk("R1 restart", ack, 1);
        send_byte(8'h40, ack);           chk("R1 restart", ack, 1);
        ref_addr = 9'h040;
        bus_start();
        send_byte(dev(1'b1, 1'b0), ack); chk("R1 restart", ack, 1);
        read_bytes(1, "R1", 1'b1);

        // random mix
        for (int it = 0; it < 30; it++) begin
            kind = int'($urandom_range(0, 2));
            a    = 9'($urandom);
            n    = int'($urandom_range(1, 10));
            if (kind == 0) begin
                wp = ($urandom_range(0, 3) == 0);
                write_txn(a, n);
                wp = 1'b0;
            end else if (kind == 1) begin
                read_random(a, n, "R6", 1'b1);
            end else begin
                read_current(n, "R9");
            end
        end

        chk("R11", viol, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule